// File: doc/BRIEF.md
# DLL delay code controller

This block holds the delay setting that a delay-locked loop applies to its delay chain. An external phase comparator tells it, one reference-clock cycle at a time, whether the chain is too short or too long. When the comparator's qualifying enable is high, the block moves a 7-bit delay code one step up or down. The code is kept in a Gray-coded up/down counter, so that each step flips exactly one bit. The counter stops at both ends of the range and does not wrap.

After every reset the block runs a lock timer and raises a locked flag once the settle time for the selected mode has passed. The long low-jitter mode waits 2560 cycles and the normal mode waits 512. Downstream delay consumers do not follow the live code. They see a copy that changes only on cycles where the update strobe is high. A second output gives the live code in binary with a user phase offset added or subtracted, clamped to the code range.

Top module: `dll_code_ctrl`

## Requirements
- R1: While rst_n is low, asynchronously and independent of the clock: code_o = 7'h60 (the Gray form of binary 64), upd_code_o = 64 and locked_o = 0. The release of rst_n is synchronised through two flops. Up/down input is therefore ignored on the first two rising edges after rst_n rises.
- R2: On a rising edge with updn_en_i = 1, the binary value of the delay code rises by one if updn_i = 1 and falls by one if updn_i = 0. code_o always carries the Gray form g = b ^ (b >> 1) of the binary value b. Two consecutive values of code_o differ in at most one bit.
- R3: On a rising edge with updn_en_i = 0, code_o does not change, whatever the value of updn_i.
- R4: The binary code saturates. An up step at 127 (code_o = 7'h40) leaves it at 127, and a down step at 0 (code_o = 7'h00) leaves it at 0.
- R5: locked_o rises on rising edge number N+2 after rst_n rises, where the two extra edges come from the reset synchroniser. N is 2560 when lowjit_i = 1 and 512 when lowjit_i = 0. lowjit_i is held stable during the wait.
- R6: Once locked_o is high, it stays high until the next assertion of rst_n.
- R7: On a rising edge with update_i = 1, upd_code_o loads the binary delay code as it stood before that edge. If a count step falls on the same edge, upd_code_o takes the value from before the step. When update_i = 0, upd_code_o holds its value.
- R8: When off_sub_i = 0, off_code_o = min(b + offset_i, 127), where b is the current binary code.
- R9: When off_sub_i = 1, off_code_o = max(b - offset_i, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low load/reset, released synchronously |
| updn_i | input | 1 | Phase comparator decision: 1 = step up, 0 = step down |
| updn_en_i | input | 1 | Qualifies updn_i for this cycle |
| lowjit_i | input | 1 | Lock-time select: 1 = 2560 cycles, 0 = 512 cycles |
| update_i | input | 1 | Strobe that loads the code into upd_code_o |
| offset_i | input | 7 | Phase offset magnitude |
| off_sub_i | input | 1 | 1 = subtract offset, 0 = add offset |
| code_o | output | 7 | Live delay code, Gray coded |
| upd_code_o | output | 7 | Binary delay code, updated only on update_i |
| off_code_o | output | 7 | Saturated binary code plus or minus the offset |
| locked_o | output | 1 | Lock time has elapsed since the last reset |

## Verification
A count step and the update strobe can land on the same rising edge. That edge decides whether downstream consumers see the old or the new code. The bench provokes this by raising updn_en_i, updn_i and update_i together on one cycle. It then requires upd_code_o to hold the pre-step value while code_o already shows the stepped Gray code. A later step with update_i low confirms that upd_code_o stays put.

// File: rtl/dll_code_pkg.sv
package dll_code_pkg;

  localparam int unsigned CODE_W = 7;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_MAX = '1;
  localparam code_t CODE_MIN = '0;
  localparam code_t CODE_MID = code_t'(1) << (CODE_W - 1);

  function automatic code_t bin2gray(code_t b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/dll_rst_sync.sv
module dll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dll_gray_updn.sv
module dll_gray_updn
  import dll_code_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_en,
  input  logic  step_up,
  output code_t gray_o,
  output code_t bin_o
);

  code_t gray_q;
  code_t gray_d;
  code_t bin_cur;
  code_t bin_nxt;

  // Gray to binary: each binary bit is the XOR of all Gray bits at or above it
  assign bin_cur[CODE_W-1] = gray_q[CODE_W-1];
  generate
    for (genvar i = CODE_W - 2; i >= 0; i--) begin : g_g2b
      assign bin_cur[i] = bin_cur[i+1] ^ gray_q[i];
    end
  endgenerate

  always_comb begin
    bin_nxt = bin_cur;
    if (step_en) begin
      if (step_up) begin
        if (bin_cur != CODE_MAX) bin_nxt = bin_cur + code_t'(1);
      end else begin
        if (bin_cur != CODE_MIN) bin_nxt = bin_cur - code_t'(1);
      end
    end
    gray_d = bin2gray(bin_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_q <= bin2gray(CODE_MID);
    end else if (step_en) begin
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;
  assign bin_o  = bin_cur;

endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
  parameter int unsigned LONG_CYC  = 2560,
  parameter int unsigned SHORT_CYC = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_mode,
  output logic locked_o
);

  localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;
  logic             lock_q;
  logic             lock_d;
  logic             run_en;

  assign limit  = long_mode ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
  assign run_en = !lock_q;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (cnt_q >= limit) begin
      lock_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (run_en) begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked_o = lock_q;

endmodule

// File: rtl/dll_offset_stage.sv
module dll_offset_stage
  import dll_code_pkg::*;
(
  input  code_t base_i,
  input  code_t offset_i,
  input  logic  sub_i,
  output code_t result_o
);

  logic [CODE_W:0] sum_w;
  logic [CODE_W:0] diff_w;

  assign sum_w  = {1'b0, base_i} + {1'b0, offset_i};
  assign diff_w = {1'b0, base_i} - {1'b0, offset_i};

  always_comb begin
    if (sub_i) begin
      result_o = diff_w[CODE_W] ? CODE_MIN : diff_w[CODE_W-1:0];
    end else begin
      result_o = sum_w[CODE_W] ? CODE_MAX : sum_w[CODE_W-1:0];
    end
  end

endmodule

// File: rtl/dll_code_ctrl.sv
module dll_code_ctrl
  import dll_code_pkg::*;
#(
  parameter int unsigned LOCK_LONG   = 2560,
  parameter int unsigned LOCK_SHORT  = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              updn_i,
  input  logic              updn_en_i,
  input  logic              lowjit_i,
  input  logic              update_i,
  input  logic [CODE_W-1:0] offset_i,
  input  logic              off_sub_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] upd_code_o,
  output logic [CODE_W-1:0] off_code_o,
  output logic              locked_o
);

  logic  srst_n;
  code_t gray_w;
  code_t bin_w;
  code_t upd_q;
  code_t upd_d;

  dll_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dll_gray_updn u_counter (
    .clk     (clk),
    .rst_n   (srst_n),
    .step_en (updn_en_i),
    .step_up (updn_i),
    .gray_o  (gray_w),
    .bin_o   (bin_w)
  );

  dll_lock_timer #(
    .LONG_CYC  (LOCK_LONG),
    .SHORT_CYC (LOCK_SHORT)
  ) u_lock (
    .clk       (clk),
    .rst_n     (srst_n),
    .long_mode (lowjit_i),
    .locked_o  (locked_o)
  );

  dll_offset_stage u_offset (
    .base_i   (bin_w),
    .offset_i (offset_i),
    .sub_i    (off_sub_i),
    .result_o (off_code_o)
  );

  // Downstream copy: only moves on the update strobe
  always_comb begin
    upd_d = bin_w;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      upd_q <= CODE_MID;
    end else if (update_i) begin
      upd_q <= upd_d;
    end
  end

  assign code_o     = gray_w;
  assign upd_code_o = upd_q;

endmodule

// File: rtl/dll_code_ctrl_chk.sv
module dll_code_ctrl_chk
  import dll_code_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        updn_i,
  input logic        updn_en_i,
  input logic        update_i,
  input logic [6:0]  code_o,
  input logic [6:0]  upd_code_o,
  input logic        locked_o
);

  localparam code_t GRAY_TOP = bin2gray(CODE_MAX);
  localparam code_t GRAY_BOT = bin2gray(CODE_MIN);

  a_r2_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != $past(code_o)) |-> ($countones(code_o ^ $past(code_o)) == 1));

  a_r3_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !updn_en_i |=> $stable(code_o));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == GRAY_TOP && updn_en_i && updn_i) |=> (code_o == GRAY_TOP));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == GRAY_BOT && updn_en_i && !updn_i) |=> (code_o == GRAY_BOT));

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o);

  a_r7_update_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !update_i |=> $stable(upd_code_o));

endmodule

bind dll_code_ctrl dll_code_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .updn_i     (updn_i),
  .updn_en_i  (updn_en_i),
  .update_i   (update_i),
  .code_o     (code_o),
  .upd_code_o (upd_code_o),
  .locked_o   (locked_o)
);

// File: tb/dll_code_ctrl_tb.sv
`timescale 1ns/1ps
module dll_code_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       updn_i;
  logic       updn_en_i;
  logic       lowjit_i;
  logic       update_i;
  logic [6:0] offset_i;
  logic       off_sub_i;
  logic [6:0] code_o;
  logic [6:0] upd_code_o;
  logic [6:0] off_code_o;
  logic       locked_o;

  int n_chk  = 0;
  int n_fail = 0;
  int mbin;
  int mupd;

  always #2 clk = ~clk;

  dll_code_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .updn_i     (updn_i),
    .updn_en_i  (updn_en_i),
    .lowjit_i   (lowjit_i),
    .update_i   (update_i),
    .offset_i   (offset_i),
    .off_sub_i  (off_sub_i),
    .code_o     (code_o),
    .upd_code_o (upd_code_o),
    .off_code_o (off_code_o),
    .locked_o   (locked_o)
  );

  function automatic int to_gray(int b);
    return (b ^ (b >> 1)) & 127;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    rst_n = 1'b0; updn_en_i = 1'b0; updn_i = 1'b0; update_i = 1'b0;
    lowjit_i = mode;
    #7;
    check("R1 code in reset", int'(code_o), 'h60);
    check("R1 upd in reset", int'(upd_code_o), 64);
    check("R1 locked in reset", int'(locked_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mbin = 64; mupd = 64;
  endtask

  task automatic t_lock(logic mode, int n);
    do_reset(mode);
    repeat (n + 1) @(posedge clk);
    #1 check("R5 not yet locked", int'(locked_o), 0);
    @(posedge clk);
    #1 check("R5 locked at limit", int'(locked_o), 1);
    repeat (30) @(posedge clk);
    #1 check("R6 lock stays", int'(locked_o), 1);
    check("R1 code after release", int'(code_o), 'h60);
  endtask

  task automatic step(logic up, logic en, logic upd, string tag);
    int prev;
    int prev_code;
    prev_code = int'(code_o);
    @(negedge clk);
    updn_i = up; updn_en_i = en; update_i = upd;
    @(posedge clk);
    #1;
    prev = mbin;
    if (en) begin
      if (up && mbin < 127) mbin++;
      else if (!up && mbin > 0) mbin--;
    end
    if (upd) mupd = prev;
    check(tag, int'(code_o), to_gray(mbin));
    check("R2 one bit", ($countones(code_o ^ 7'(prev_code)) <= 1) ? 1 : 0, 1);
    check("R7 upd value", int'(upd_code_o), mupd);
  endtask

  task automatic t_up();
    for (int i = 0; i < 70; i++)
      step(1'b1, 1'b1, 1'b0, (mbin == 127) ? "R4 top saturate" : "R2 up step");
    check("R4 at top", int'(code_o), 'h40);
  endtask

  task automatic t_down();
    for (int i = 0; i < 140; i++)
      step(1'b0, 1'b1, 1'b0, (mbin == 0) ? "R4 bottom saturate" : "R2 down step");
    check("R4 at bottom", int'(code_o), 0);
  endtask

  task automatic t_enable();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, "R2 up step");
    for (int i = 0; i < 12; i++) step(i[0], 1'b0, 1'b0, "R3 gated");
  endtask

  task automatic off_case(logic sub, int off, int exp, string tag);
    @(negedge clk);
    off_sub_i = sub; offset_i = 7'(off);
    #1 check(tag, int'(off_code_o), exp);
  endtask

  task automatic t_offset();
    while (mbin < 100) step(1'b1, 1'b1, 1'b0, "R2 up step");
    updn_en_i = 1'b0;
    off_case(1'b0, 20, 120, "R8 add");
    off_case(1'b0, 40, 127, "R8 add saturate");
    off_case(1'b0, 0, 100, "R8 add zero");
    off_case(1'b1, 30, 70, "R9 subtract");
    off_case(1'b1, 120, 0, "R9 subtract saturate");
    off_case(1'b1, 100, 0, "R9 subtract to zero");
  endtask

  task automatic t_update();
    step(1'b1, 1'b1, 1'b1, "R7 step with update");
    check("R7 coincident old value", int'(upd_code_o), 100);
    step(1'b1, 1'b1, 1'b0, "R7 step without update");
    check("R7 held", int'(upd_code_o), 100);
    step(1'b0, 1'b0, 1'b1, "R7 plain update");
    check("R7 loaded", int'(upd_code_o), 102);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; updn_i = 1'b0; updn_en_i = 1'b0; lowjit_i = 1'b1;
    update_i = 1'b0; offset_i = '0; off_sub_i = 1'b0;
    t_lock(1'b1, 2560);
    t_lock(1'b0, 512);
    t_up();
    t_down();
    t_enable();
    t_offset();
    t_update();
    t_lock(1'b0, 512);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule